// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block is the register file and bus of a small accumulator machine. Six registers and a word-addressed memory share one 16-bit bus. A 3-bit source select decides which of them drives the bus in a given cycle. Every register has three controls: load, increment and clear. A register that loads takes its value from the bus on the rising clock edge.

The address register and the program counter are 12 bits wide. The data, accumulator, instruction and temporary registers are 16 bits wide. The memory is read and written only at the location held in the address register.

The accumulator is special: its load control takes a value from a separate ALU result input and never from the bus. This lets two transfers share one cycle, for example:
- the data register loads the accumulator from the bus, and
- in the same cycle, the accumulator loads the old data register value that the ALU path passes back.

An external sequencer drives the select and control lines. The ALU and the sequencing are not part of this block.

Register index used by the control vectors `reg_ld`, `reg_inr` and `reg_clr`:
- 0 address register
- 1 program counter
- 2 data register
- 3 accumulator
- 4 instruction register
- 5 temporary register

The block has no state machine. Its only states are the register contents, and a register changes only through the transitions clear, load, increment and hold.

Top module: `regbus_datapath`

## Requirements
- R1: The bus carries one source per cycle, chosen by `bus_sel`: 000 gives zero, 001 the address register, 010 the program counter, 011 the data register, 100 the accumulator, 101 the instruction register, 110 the temporary register, and 111 the memory word at the address register.
- R2: When the 12-bit address register or program counter drives the bus, bus bits 15..12 are zero.
- R3: A register whose `reg_ld` bit is set captures the bus value (bits 11..0 for the 12-bit registers) at the clock edge. A register whose `reg_ld`, `reg_inr` and `reg_clr` bits are all clear holds its value.
- R4: Within one register, clear wins over load and load wins over increment.
- R5: Incrementing a 12-bit register that holds 0xFFF gives 0x000.
- R6: With `mem_wr` high, the current bus value is stored at the clock edge into the memory word addressed by the low `MEM_AW` bits of the address register. The other words are unchanged.
- R7: The accumulator load (bit 3) takes `alu_res`, not the bus. The bus never reaches the accumulator by any other path.
- R8: A data register load from the accumulator and an accumulator load from `alu_res` in the same cycle both take effect, so the two values are exchanged.
- R9: While `rst_n` is low, all six registers are zero.
- R10: Incrementing a 16-bit register that holds 0xFFFF gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 3 | Bus source select |
| reg_ld | input | 6 | Per-register load controls |
| reg_inr | input | 6 | Per-register increment controls |
| reg_clr | input | 6 | Per-register clear controls |
| alu_res | input | 16 | ALU result, the accumulator load source |
| mem_wr | input | 1 | Store the bus value at the memory word addressed by the address register |
| bus_q | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |

## Verification
The bench loads 16-bit values whose upper nibble is set into the address register and the program counter. A design that failed to zero-extend would show those bits again on the bus.

It raises clear, load and increment together, and load with increment. A wrong priority leaves a nonzero or incremented value.

It wraps both register widths, writes two adjacent memory words and reads the first back, and drives the bus with one value while offering the accumulator a different ALU value. A design that fed the bus into the accumulator would load the bus value, and one that could not share a cycle would lose one side of the exchange.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    typedef enum logic [2:0] {
        SRC_NONE = 3'b000,
        SRC_AR   = 3'b001,
        SRC_PC   = 3'b010,
        SRC_DR   = 3'b011,
        SRC_AC   = 3'b100,
        SRC_IR   = 3'b101,
        SRC_TR   = 3'b110,
        SRC_MEM  = 3'b111
    } bus_src_e;

    localparam int IDX_AR = 0;
    localparam int IDX_PC = 1;
    localparam int IDX_DR = 2;
    localparam int IDX_AC = 3;
    localparam int IDX_IR = 4;
    localparam int IDX_TR = 5;
    localparam int NUM_REGS = 6;

endpackage

// File: rtl/regbus_cell.sv
module regbus_cell #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic             inr,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef enum logic [1:0] {ACT_HOLD, ACT_CLR, ACT_LD, ACT_INR} act_e;
    act_e act;

    // Priority: clear, then load, then increment.
    always_comb begin
        if (clr)      act = ACT_CLR;
        else if (ld)  act = ACT_LD;
        else if (inr) act = ACT_INR;
        else          act = ACT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_CLR:  q <= '0;
                ACT_LD:   q <= d;
                ACT_INR:  q <= q + WIDTH'(1);
                ACT_HOLD: q <= q;
                default:  q <= q;
            endcase
        end
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0)); // R4
    AST_LD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> (q == $past(d))); // R3
    AST_INR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && inr) |=> (q == $past(q) + WIDTH'(1))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && !inr) |=> $stable(q)); // R3

endmodule

// File: rtl/regbus_mem.sv
module regbus_mem #(
    parameter int DW     = 16,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [MEM_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) words[addr] <= wdata;
    end

    assign rdata = words[addr];

endmodule

// File: rtl/regbus_mux.sv
module regbus_mux
    import regbus_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic [2:0]    sel,
    input  logic [AW-1:0] ar,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] dr,
    input  logic [DW-1:0] ac,
    input  logic [DW-1:0] ir,
    input  logic [DW-1:0] tr,
    input  logic [DW-1:0] mem,
    output logic [DW-1:0] bus
);

    bus_src_e src;
    assign src = bus_src_e'(sel);

    always_comb begin
        unique case (src)
            SRC_NONE: bus = '0;
            SRC_AR:   bus = DW'(ar);
            SRC_PC:   bus = DW'(pc);
            SRC_DR:   bus = dr;
            SRC_AC:   bus = ac;
            SRC_IR:   bus = ir;
            SRC_TR:   bus = tr;
            SRC_MEM:  bus = mem;
            default:  bus = '0;
        endcase
    end

endmodule

// File: rtl/regbus_datapath.sv
module regbus_datapath
    import regbus_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 12,
    parameter int MEM_AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_sel,
    input  logic [NUM_REGS-1:0] reg_ld,
    input  logic [NUM_REGS-1:0] reg_inr,
    input  logic [NUM_REGS-1:0] reg_clr,
    input  logic [DW-1:0]       alu_res,
    input  logic                mem_wr,
    output logic [DW-1:0]       bus_q,
    output logic [AW-1:0]       ar_q,
    output logic [AW-1:0]       pc_q,
    output logic [DW-1:0]       dr_q,
    output logic [DW-1:0]       ac_q,
    output logic [DW-1:0]       ir_q,
    output logic [DW-1:0]       tr_q
);

    logic [DW-1:0] bus;
    logic [DW-1:0] mem_rdata;

    regbus_mux #(.DW(DW), .AW(AW)) mux_i (
        .sel(bus_sel), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
        .ir(ir_q), .tr(tr_q), .mem(mem_rdata), .bus(bus)
    );

    regbus_mem #(.DW(DW), .MEM_AW(MEM_AW)) mem_i (
        .clk(clk), .wr(mem_wr), .addr(ar_q[MEM_AW-1:0]),
        .wdata(bus), .rdata(mem_rdata)
    );

    regbus_cell #(.WIDTH(AW)) ar_i (
        .clk(clk), .rst_n(rst_n), .ld(reg_ld[IDX_AR]), .inr(reg_inr[IDX_AR]),
        .clr(reg_clr[IDX_AR]), .d(bus[AW-1:0]), .q(ar_q)
    );
    regbus_cell #(.WIDTH(AW)) pc_i (
        .clk(clk), .rst_n(rst_n), .ld(reg_ld[IDX_PC]), .inr(reg_inr[IDX_PC]),
        .clr(reg_clr[IDX_PC]), .d(bus[AW-1:0]), .q(pc_q)
    );
    regbus_cell #(.WIDTH(DW)) dr_i (
        .clk(clk), .rst_n(rst_n), .ld(reg_ld[IDX_DR]), .inr(reg_inr[IDX_DR]),
        .clr(reg_clr[IDX_DR]), .d(bus), .q(dr_q)
    );
    // Accumulator: load source is the ALU result, never the bus.
    regbus_cell #(.WIDTH(DW)) ac_i (
        .clk(clk), .rst_n(rst_n), .ld(reg_ld[IDX_AC]), .inr(reg_inr[IDX_AC]),
        .clr(reg_clr[IDX_AC]), .d(alu_res), .q(ac_q)
    );
    regbus_cell #(.WIDTH(DW)) ir_i (
        .clk(clk), .rst_n(rst_n), .ld(reg_ld[IDX_IR]), .inr(reg_inr[IDX_IR]),
        .clr(reg_clr[IDX_IR]), .d(bus), .q(ir_q)
    );
    regbus_cell #(.WIDTH(DW)) tr_i (
        .clk(clk), .rst_n(rst_n), .ld(reg_ld[IDX_TR]), .inr(reg_inr[IDX_TR]),
        .clr(reg_clr[IDX_TR]), .d(bus), .q(tr_q)
    );

    assign bus_q = bus;

    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SRC_AR || bus_sel == SRC_PC) |-> (bus_q[DW-1:AW] == '0)); // R2
    AST_AC_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ld[IDX_AC] && !reg_clr[IDX_AC]) |=> (ac_q == $past(alu_res))); // R7
    AST_MEM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !reg_ld[IDX_AR] && !reg_inr[IDX_AR] && !reg_clr[IDX_AR])
        |=> ((bus_sel == SRC_MEM) -> (bus_q == $past(bus_q)))); // R6
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (ar_q == '0 && pc_q == '0 && ac_q == '0 && dr_q == '0)); // R9

endmodule

// File: tb/regbus_datapath_tb_top.sv
module regbus_datapath_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = 3'b000;
    logic [5:0]  reg_ld = '0;
    logic [5:0]  reg_inr = '0;
    logic [5:0]  reg_clr = '0;
    logic [15:0] alu_res = '0;
    logic        mem_wr = 1'b0;
    logic [15:0] bus_q;
    logic [11:0] ar_q;
    logic [11:0] pc_q;
    logic [15:0] dr_q;
    logic [15:0] ac_q;
    logic [15:0] ir_q;
    logic [15:0] tr_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    regbus_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .reg_ld(reg_ld),
        .reg_inr(reg_inr), .reg_clr(reg_clr), .alu_res(alu_res), .mem_wr(mem_wr),
        .bus_q(bus_q), .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q),
        .ir_q(ir_q), .tr_q(tr_q)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply controls for one clock edge; outputs are settled on return.
    task automatic step(input logic [2:0] s, input logic [5:0] ld, input logic [5:0] inr,
                        input logic [5:0] clr, input logic [15:0] alu, input logic wr);
        bus_sel = s; reg_ld = ld; reg_inr = inr; reg_clr = clr; alu_res = alu; mem_wr = wr;
        @(posedge clk);
        #2;
        bus_sel = 3'b000; reg_ld = '0; reg_inr = '0; reg_clr = '0; mem_wr = 1'b0;
    endtask

    // Put a value into register idx through the accumulator and the bus.
    task automatic put(input int idx, input logic [15:0] val);
        step(3'b000, 6'b001000, '0, '0, val, 1'b0);
        if (idx != 3) step(3'b100, 6'(1 << idx), '0, '0, '0, 1'b0);
    endtask

    task automatic peek(input logic [2:0] s, output logic [15:0] v);
        bus_sel = s;
        #1;
        v = bus_q;
        bus_sel = 3'b000;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R9 ar", 16'(ar_q), 16'h0);
        check("R9 pc", 16'(pc_q), 16'h0);
        check("R9 ac", ac_q, 16'h0);
        check("R9 dr", dr_q, 16'h0);
        check("R9 ir", ir_q, 16'h0);
        check("R9 tr", tr_q, 16'h0);
        peek(3'b000, v); check("R1 sel000 zero", v, 16'h0);
    endtask

    task automatic t_sources;
        logic [15:0] v;
        put(0, 16'hBEEF);
        check("R3 ar load low bits", 16'(ar_q), 16'h0EEF);
        peek(3'b001, v); check("R2 ar zero-extended", v, 16'h0EEF);
        put(1, 16'hF123);
        peek(3'b010, v); check("R2 pc zero-extended", v, 16'h0123);
        put(2, 16'h1357);
        peek(3'b011, v); check("R1 sel011 dr", v, 16'h1357);
        put(4, 16'h2468);
        peek(3'b101, v); check("R1 sel101 ir", v, 16'h2468);
        put(5, 16'h9ABC);
        peek(3'b110, v); check("R1 sel110 tr", v, 16'h9ABC);
        peek(3'b100, v); check("R1 sel100 ac", v, 16'h9ABC);
        step(3'b000, '0, '0, '0, 16'hFFFF, 1'b0);
        check("R3 idle hold dr", dr_q, 16'h1357);
        check("R7 ac holds without load", ac_q, 16'h9ABC);
    endtask

    task automatic t_priority;
        put(0, 16'h0055);
        step(3'b110, 6'b000001, 6'b000001, 6'b000001, '0, 1'b0);
        check("R4 clear beats load and inc", 16'(ar_q), 16'h0000);
        step(3'b110, 6'b000001, 6'b000001, '0, '0, 1'b0);
        check("R4 load beats inc", 16'(ar_q), 16'h0ABC);
        step(3'b000, '0, 6'b000001, '0, '0, 1'b0);
        check("R4 inc alone", 16'(ar_q), 16'h0ABD);
    endtask

    task automatic t_wrap;
        put(1, 16'h0FFF);
        step(3'b000, '0, 6'b000010, '0, '0, 1'b0);
        check("R5 pc wraps", 16'(pc_q), 16'h0000);
        put(2, 16'hFFFF);
        step(3'b000, '0, 6'b000100, '0, '0, 1'b0);
        check("R10 dr wraps", dr_q, 16'h0000);
    endtask

    task automatic t_memory;
        logic [15:0] v;
        put(5, 16'hC0DE);
        put(0, 16'h0012);
        step(3'b110, '0, '0, '0, '0, 1'b1);
        peek(3'b111, v); check("R6 read back word 0x12", v, 16'hC0DE);
        put(5, 16'h7E57);
        step(3'b000, '0, 6'b000001, '0, '0, 1'b0);
        step(3'b110, '0, '0, '0, '0, 1'b1);
        peek(3'b111, v); check("R6 word 0x13", v, 16'h7E57);
        put(0, 16'h0012);
        peek(3'b111, v); check("R6 word 0x12 untouched", v, 16'hC0DE);
        step(3'b111, 6'b000100, '0, '0, '0, 1'b0);
        check("R6 dr from memory", dr_q, 16'hC0DE);
    endtask

    task automatic t_acc;
        put(2, 16'hABCD);
        step(3'b000, 6'b001000, '0, '0, 16'h1234, 1'b0);
        step(3'b011, 6'b001000, '0, '0, 16'h5555, 1'b0);
        check("R7 ac takes alu not bus", ac_q, 16'h5555);
        step(3'b000, 6'b001000, '0, '0, 16'h1234, 1'b0);
        // Swap: DR <- AC over the bus, AC <- old DR over the ALU path.
        step(3'b100, 6'b001100, '0, '0, 16'hABCD, 1'b0);
        check("R8 dr got old ac", dr_q, 16'h1234);
        check("R8 ac got old dr", ac_q, 16'hABCD);
        step(3'b000, '0, 6'b001000, '0, '0, 1'b0);
        check("R7 ac increment", ac_q, 16'hABCE);
        step(3'b000, '0, '0, 6'b001000, '0, 1'b0);
        check("R7 ac clear", ac_q, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        t_sources;
        t_priority;
        t_wrap;
        t_memory;
        t_acc;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule